// File: doc/BRIEF.md
# Deep-Off Supply Sequencer

This block moves a chip into a deep off state and brings it back out. When the running chip requests entry, it steps through the shutdown one output per clock cycle. First the memory regulators are switched off. Then the off-mode output is raised, which removes both main supply rails. Then the wake-up regulator is dropped to its retention level. Finally the clock request and the oscillator enable are released. After that the block idles until a wake event arrives.

On wake-up, the block restores the oscillator, the clock request and the full wake-up regulator level, and waits for the longer of two programmed settling counts. It then brings up the second rail (VDD2) and, only after that rail's setup count has expired, the first rail (VDD1), which has its own setup count. Each rail is restored in one of two ways, selected by a legacy-select input:

- **Command mode:** an on-voltage command is offered on a valid/ready port.
- **Legacy mode:** the rail's active-low mode pin is simply released.

Once both rails are up, the memory regulators are re-enabled, the analog cells are powered, and after a fixed settling time a one-cycle handoff pulse tells the domain reset logic to proceed.

Top module: `offseq_top`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, the block is in the running state:
  - `mem_ldo_en`, `wldo_full`, `clk_req`, `osc_en` and `analog_en` are 1.
  - Both mode pins are 1.
  - `off_mode`, `cmd_valid` and `handoff` are 0.
- R2: When `enter_req` is high at a clock edge in the running state, the outputs change one step per cycle, in this order:
  - `mem_ldo_en` falls.
  - `off_mode` rises, and in the same cycle both mode pins and `analog_en` fall.
  - `wldo_full` falls.
  - `clk_req` and `osc_en` fall.
  - The block then idles.
- R3: A wake event taken in idle makes `osc_en`, `clk_req` and `wldo_full` rise and `off_mode` fall in the same cycle. That step lasts M+1 cycles, where M is the larger of `osc_wait` and `ldo_wait`.
- R4: The VDD2 step comes first.
  - `rail2_mode_n` rises at that step.
  - In command mode, `cmd_valid` is 1 with `cmd_rail`=0 and `cmd_volt`=`rail2_on_volt`.
  - The VDD1 step begins exactly `rail2_setup`+1 cycles after the VDD2 step is left.
- R5: At the VDD1 step:
  - `rail1_mode_n` rises.
  - In command mode, `cmd_valid` is 1 with `cmd_rail`=1 and `cmd_volt`=`rail1_on_volt`.
  - `mem_ldo_en` rises exactly `rail1_setup`+1 cycles after this step is left.
- R6: With `legacy_sel`=1:
  - `cmd_valid` stays 0 throughout.
  - Each rail step lasts one cycle, with no wait on `cmd_ready`.
- R7: In command mode, a rail step ends only at an edge where `cmd_ready` is 1. While it waits, `cmd_valid`, `cmd_rail` and `cmd_volt` stay stable, and that rail's setup count does not start.
- R8: Bring-up finishes in this order:
  - `mem_ldo_en` is 1 for one cycle with `analog_en` 0.
  - `analog_en` is then 1 for ANA_SETTLE+1 cycles before `handoff`.
  - `handoff` is 1 for exactly one cycle.
  - The block then returns to the running state.
- R9: A `wake_evt` pulse seen during any of the four shutdown steps is held. The block spends one cycle in idle and then starts the wake sequence with no further event.
- R10: `wake_evt` has no effect in the running state or during the wake sequence, and `enter_req` has no effect outside the running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| enter_req | input | 1 | Request to enter the deep off state |
| wake_evt | input | 1 | Wake-up event |
| legacy_sel | input | 1 | 1 = restore rails through mode pins, 0 = voltage commands |
| rail2_on_volt | input | VOLT_W | On-voltage code for VDD2 |
| rail1_on_volt | input | VOLT_W | On-voltage code for VDD1 |
| osc_wait | input | CNT_W | Oscillator settling count |
| ldo_wait | input | CNT_W | Wake-up regulator settling count |
| rail2_setup | input | CNT_W | VDD2 setup count |
| rail1_setup | input | CNT_W | VDD1 setup count |
| cmd_ready | input | 1 | Rail command accepted |
| mem_ldo_en | output | 1 | Memory regulator enable |
| off_mode | output | 1 | Off-mode output, removes both rails |
| wldo_full | output | 1 | Wake-up regulator at full level (0 = retention) |
| clk_req | output | 1 | System clock request |
| osc_en | output | 1 | Oscillator enable |
| analog_en | output | 1 | Analog cell power on the VDD2 domain |
| rail2_mode_n | output | 1 | Active-low legacy mode pin for VDD2 |
| rail1_mode_n | output | 1 | Active-low legacy mode pin for VDD1 |
| cmd_valid | output | 1 | Rail command offered |
| cmd_rail | output | 1 | Rail of the command (0 = VDD2, 1 = VDD1) |
| cmd_volt | output | VOLT_W | Voltage code of the command |
| handoff | output | 1 | One-cycle pulse to the domain reset logic |

## Verification
The checker enforces the following on every cycle:
- **Shutdown ordering:** the memory regulators are off whenever `off_mode` is up, and the clock request is released only after retention is reached.
- **Wake-up grouping:** the oscillator, the clock request and the full regulator level return together.
- **Rail order:** VDD1 is never released ahead of VDD2.
- **Command stability:** a command is held stable while it is not accepted.
- **Handoff shape:** the handoff is a one-cycle pulse with the supplies restored.

The exact lengths of the timed steps, the voltage codes offered, the latching of an early wake event, and the stimuli that must be ignored can only be shown by the bench's sweeps over counts, modes and ready delays.

// File: rtl/offseq_pkg.sv
package offseq_pkg;

    typedef enum logic [3:0] {
        ST_RUN,
        ST_E_MEM,
        ST_E_OFF,
        ST_E_WLDO,
        ST_E_CLK,
        ST_IDLE,
        ST_W_START,
        ST_R2_CMD,
        ST_R2_SET,
        ST_R1_CMD,
        ST_R1_SET,
        ST_MEM,
        ST_ANA,
        ST_HANDOFF
    } seq_state_t;

    // Rail identifiers on the command port
    localparam logic RAIL_ID_VDD2 = 1'b0;
    localparam logic RAIL_ID_VDD1 = 1'b1;

    // Level of every supply-control output for one step
    typedef struct packed {
        logic mem;
        logic off;
        logic wldo;
        logic clk;
        logic ana;
        logic m2n;
        logic m1n;
    } pwr_out_t;

    function automatic logic in_entry(seq_state_t s);
        return (s == ST_E_MEM) || (s == ST_E_OFF) ||
               (s == ST_E_WLDO) || (s == ST_E_CLK);
    endfunction

endpackage

// File: rtl/offseq_timer.sv
module offseq_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/offseq_wake_latch.sv
module offseq_wake_latch (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic pend
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
        end else if (clr) begin
            pend <= 1'b0;
        end else if (set) begin
            pend <= 1'b1;
        end
    end
endmodule

// File: rtl/offseq_outdec.sv
module offseq_outdec
    import offseq_pkg::*;
(
    input  seq_state_t st,
    output pwr_out_t   pwr
);
    always_comb begin
        pwr.mem  = !(st inside {ST_E_MEM, ST_E_OFF, ST_E_WLDO, ST_E_CLK, ST_IDLE,
                                ST_W_START, ST_R2_CMD, ST_R2_SET, ST_R1_CMD, ST_R1_SET});
        pwr.off  = st inside {ST_E_OFF, ST_E_WLDO, ST_E_CLK, ST_IDLE};
        pwr.wldo = !(st inside {ST_E_WLDO, ST_E_CLK, ST_IDLE});
        pwr.clk  = !(st inside {ST_E_CLK, ST_IDLE});
        pwr.ana  = !(st inside {ST_E_OFF, ST_E_WLDO, ST_E_CLK, ST_IDLE, ST_W_START,
                                ST_R2_CMD, ST_R2_SET, ST_R1_CMD, ST_R1_SET, ST_MEM});
        pwr.m2n  = !(st inside {ST_E_OFF, ST_E_WLDO, ST_E_CLK, ST_IDLE, ST_W_START});
        pwr.m1n  = !(st inside {ST_E_OFF, ST_E_WLDO, ST_E_CLK, ST_IDLE, ST_W_START,
                                ST_R2_CMD, ST_R2_SET});
    end
endmodule

// File: rtl/offseq_top.sv
module offseq_top
    import offseq_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int VOLT_W     = 8,
    parameter int ANA_SETTLE = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enter_req,
    input  logic              wake_evt,
    input  logic              legacy_sel,
    input  logic [VOLT_W-1:0] rail2_on_volt,
    input  logic [VOLT_W-1:0] rail1_on_volt,
    input  logic [CNT_W-1:0]  osc_wait,
    input  logic [CNT_W-1:0]  ldo_wait,
    input  logic [CNT_W-1:0]  rail2_setup,
    input  logic [CNT_W-1:0]  rail1_setup,
    input  logic              cmd_ready,
    output logic              mem_ldo_en,
    output logic              off_mode,
    output logic              wldo_full,
    output logic              clk_req,
    output logic              osc_en,
    output logic              analog_en,
    output logic              rail2_mode_n,
    output logic              rail1_mode_n,
    output logic              cmd_valid,
    output logic              cmd_rail,
    output logic [VOLT_W-1:0] cmd_volt,
    output logic              handoff
);
    localparam logic [CNT_W-1:0] ANA_CNT = CNT_W'(ANA_SETTLE);

    seq_state_t       st_q, st_d;
    logic             t_load, t_done, pend, accept;
    logic [CNT_W-1:0] t_val, start_wait;
    pwr_out_t         pwr;

    assign start_wait = (osc_wait > ldo_wait) ? osc_wait : ldo_wait;
    assign accept     = legacy_sel || cmd_ready;

    always_comb begin
        st_d   = st_q;
        t_load = 1'b0;
        t_val  = '0;
        unique case (st_q)
            ST_RUN:     if (enter_req) st_d = ST_E_MEM;
            ST_E_MEM:   st_d = ST_E_OFF;
            ST_E_OFF:   st_d = ST_E_WLDO;
            ST_E_WLDO:  st_d = ST_E_CLK;
            ST_E_CLK:   st_d = ST_IDLE;
            ST_IDLE: begin
                if (pend || wake_evt) begin
                    st_d   = ST_W_START;
                    t_load = 1'b1;
                    t_val  = start_wait;
                end
            end
            ST_W_START: if (t_done) st_d = ST_R2_CMD;
            ST_R2_CMD: begin
                if (accept) begin
                    st_d   = ST_R2_SET;
                    t_load = 1'b1;
                    t_val  = rail2_setup;
                end
            end
            ST_R2_SET:  if (t_done) st_d = ST_R1_CMD;
            ST_R1_CMD: begin
                if (accept) begin
                    st_d   = ST_R1_SET;
                    t_load = 1'b1;
                    t_val  = rail1_setup;
                end
            end
            ST_R1_SET:  if (t_done) st_d = ST_MEM;
            ST_MEM: begin
                st_d   = ST_ANA;
                t_load = 1'b1;
                t_val  = ANA_CNT;
            end
            ST_ANA:     if (t_done) st_d = ST_HANDOFF;
            ST_HANDOFF: st_d = ST_RUN;
            default:    st_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_RUN;
        else     st_q <= st_d;
    end

    offseq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .done(t_done)
    );

    offseq_wake_latch u_wake (
        .clk(clk), .rst(rst),
        .set(wake_evt && in_entry(st_q)),
        .clr(st_q == ST_IDLE),
        .pend(pend)
    );

    offseq_outdec u_dec (.st(st_q), .pwr(pwr));

    assign mem_ldo_en   = pwr.mem;
    assign off_mode     = pwr.off;
    assign wldo_full    = pwr.wldo;
    assign clk_req      = pwr.clk;
    assign osc_en       = pwr.clk;
    assign analog_en    = pwr.ana;
    assign rail2_mode_n = pwr.m2n;
    assign rail1_mode_n = pwr.m1n;

    assign cmd_valid = !legacy_sel && ((st_q == ST_R2_CMD) || (st_q == ST_R1_CMD));
    assign cmd_rail  = (st_q == ST_R1_CMD) ? RAIL_ID_VDD1 : RAIL_ID_VDD2;
    assign cmd_volt  = (st_q == ST_R1_CMD) ? rail1_on_volt : rail2_on_volt;
    assign handoff   = (st_q == ST_HANDOFF);
endmodule

// File: rtl/offseq_chk.sv
module offseq_chk #(
    parameter int VOLT_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_ldo_en,
    input logic              off_mode,
    input logic              wldo_full,
    input logic              clk_req,
    input logic              osc_en,
    input logic              analog_en,
    input logic              rail2_mode_n,
    input logic              rail1_mode_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              cmd_rail,
    input logic [VOLT_W-1:0] cmd_volt,
    input logic              handoff
);
    // R2: memory regulators and analog cells are down while rails are removed
    a_r2_off_quiet: assert property (@(posedge clk) disable iff (rst)
        off_mode |-> (!mem_ldo_en && !analog_en));

    // R2: the clock request is dropped only after retention level and off mode
    a_r2_clk_last: assert property (@(posedge clk) disable iff (rst)
        $fell(clk_req) |-> (off_mode && !wldo_full));

    // R3: oscillator, clock request and full regulator level return together
    a_r3_wake_group: assert property (@(posedge clk) disable iff (rst)
        $rose(osc_en) |-> (clk_req && wldo_full && !off_mode));

    // R4: VDD1 is never released ahead of VDD2
    a_r4_rail_order: assert property (@(posedge clk) disable iff (rst)
        rail1_mode_n |-> rail2_mode_n);

    // R7: an unaccepted command holds still
    a_r7_cmd_hold: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_rail) && $stable(cmd_volt)));

    // R8: handoff is a single-cycle pulse with supplies restored
    a_r8_handoff_pulse: assert property (@(posedge clk) disable iff (rst)
        handoff |=> !handoff);

    a_r8_handoff_ready: assert property (@(posedge clk) disable iff (rst)
        handoff |-> (mem_ldo_en && analog_en && osc_en && rail1_mode_n));
endmodule

bind offseq_top offseq_chk #(.VOLT_W(VOLT_W)) u_chk (
    .clk(clk), .rst(rst), .mem_ldo_en(mem_ldo_en), .off_mode(off_mode),
    .wldo_full(wldo_full), .clk_req(clk_req), .osc_en(osc_en),
    .analog_en(analog_en), .rail2_mode_n(rail2_mode_n),
    .rail1_mode_n(rail1_mode_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_rail(cmd_rail), .cmd_volt(cmd_volt), .handoff(handoff)
);

// File: tb/tb_offseq_top.sv
module tb_offseq_top;
    localparam int CLK_PERIOD = 10;
    localparam int ANA        = 3;

    logic        clk = 1'b0;
    logic        rst, enter_req, wake_evt, legacy_sel, cmd_ready;
    logic [7:0]  rail2_on_volt, rail1_on_volt;
    logic [15:0] osc_wait, ldo_wait, rail2_setup, rail1_setup;
    logic        mem_ldo_en, off_mode, wldo_full, clk_req, osc_en, analog_en;
    logic        rail2_mode_n, rail1_mode_n, cmd_valid, cmd_rail, handoff;
    logic [7:0]  cmd_volt;

    int nchk = 0;
    int nerr = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    offseq_top #(.CNT_W(16), .VOLT_W(8), .ANA_SETTLE(ANA)) dut (
        .clk(clk), .rst(rst), .enter_req(enter_req), .wake_evt(wake_evt),
        .legacy_sel(legacy_sel), .rail2_on_volt(rail2_on_volt),
        .rail1_on_volt(rail1_on_volt), .osc_wait(osc_wait), .ldo_wait(ldo_wait),
        .rail2_setup(rail2_setup), .rail1_setup(rail1_setup), .cmd_ready(cmd_ready),
        .mem_ldo_en(mem_ldo_en), .off_mode(off_mode), .wldo_full(wldo_full),
        .clk_req(clk_req), .osc_en(osc_en), .analog_en(analog_en),
        .rail2_mode_n(rail2_mode_n), .rail1_mode_n(rail1_mode_n),
        .cmd_valid(cmd_valid), .cmd_rail(cmd_rail), .cmd_volt(cmd_volt),
        .handoff(handoff)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, string what, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Packs all supply outputs: mem,off,wldo,clk,osc,ana,m2n,m1n
    function automatic int pwr_vec();
        return {mem_ldo_en, off_mode, wldo_full, clk_req, osc_en, analog_en,
                rail2_mode_n, rail1_mode_n};
    endfunction

    localparam int RUN_VEC = 8'b1011_1111;

    task automatic rail_step(string req, int leg, int dly, int rail, int volt);
        if (leg == 0) begin
            chk(req, "cmd_valid", int'(cmd_valid), 1);
            chk(req, "cmd_rail", int'(cmd_rail), rail);
            chk(req, "cmd_volt", int'(cmd_volt), volt);
            for (int i = 0; i < dly; i++) begin
                tick();
                chk("R7", "valid held", int'(cmd_valid), 1);
                chk("R7", "volt held", int'(cmd_volt), volt);
            end
            cmd_ready = 1'b1;
            tick();
            cmd_ready = 1'b0;
        end else begin
            chk("R6", "no command in legacy", int'(cmd_valid), 0);
            tick();
        end
    endtask

    task automatic run_case(int ow, int lw, int s2, int s1, int leg, int dly, int early);
        int n;
        int m;
        logic [7:0] v2;
        logic [7:0] v1;
        v2 = 8'(8'h30 + ow * 16 + s2);
        v1 = 8'(8'hA0 + lw * 16 + s1);
        osc_wait = 16'(ow); ldo_wait = 16'(lw);
        rail2_setup = 16'(s2); rail1_setup = 16'(s1);
        legacy_sel = leg[0]; rail2_on_volt = v2; rail1_on_volt = v1;
        m = (ow > lw) ? ow : lw;

        // R10: wake in the running state is ignored
        wake_evt = 1'b1; tick(); wake_evt = 1'b0;
        chk("R10", "wake ignored while running", pwr_vec(), RUN_VEC);
        tick();
        chk("R10", "still running", pwr_vec(), RUN_VEC);

        // R2: entry order, one step per cycle
        enter_req = 1'b1; tick(); enter_req = 1'b0;
        chk("R2", "step1 mem off", pwr_vec(), 8'b0011_1111);
        if (early != 0) wake_evt = 1'b1;
        tick(); wake_evt = 1'b0;
        chk("R2", "step2 off mode", pwr_vec(), 8'b0111_1000);
        tick();
        chk("R2", "step3 retention", pwr_vec(), 8'b0101_1000);
        tick();
        chk("R2", "step4 clock off", pwr_vec(), 8'b0100_0000);
        tick();
        chk("R2", "idle", pwr_vec(), 8'b0100_0000);
        if (early == 0) begin
            tick();
            chk("R9", "no wake, stays idle", pwr_vec(), 8'b0100_0000);
            wake_evt = 1'b1;
        end
        tick(); wake_evt = 1'b0;

        // R3: wake group and wait length
        chk("R3", "wake start outputs", pwr_vec(), 8'b0011_1000);
        n = 0;
        while (rail2_mode_n == 1'b0 && n < 500) begin n++; tick(); end
        chk("R3", "start wait cycles", n, m + 1);

        enter_req = 1'b1;   // R10: ignored during wake
        chk("R4", "VDD2 released first", int'(rail1_mode_n), 0);
        rail_step("R4", leg, dly, 0, int'(v2));
        n = 0;
        while (rail1_mode_n == 1'b0 && n < 500) begin n++; tick(); end
        chk("R4", "VDD2 setup cycles", n, s2 + 1);

        rail_step("R5", leg, dly, 1, int'(v1));
        enter_req = 1'b0;
        n = 0;
        while (mem_ldo_en == 1'b0 && n < 500) begin n++; tick(); end
        chk("R5", "VDD1 setup cycles", n, s1 + 1);

        chk("R8", "memory on, analog off", int'(analog_en), 0);
        tick();
        n = 0;
        while (handoff == 1'b0 && n < 500) begin
            n++;
            chk("R8", "analog on", int'(analog_en), 1);
            tick();
        end
        chk("R8", "analog settle cycles", n, ANA + 1);
        tick();
        chk("R8", "handoff one cycle", int'(handoff), 0);
        chk("R10", "running after wake, enter ignored", pwr_vec(), RUN_VEC);
    endtask

    initial begin
        rst = 1'b1; enter_req = 1'b0; wake_evt = 1'b0; legacy_sel = 1'b0;
        cmd_ready = 1'b0; rail2_on_volt = '0; rail1_on_volt = '0;
        osc_wait = '0; ldo_wait = '0; rail2_setup = '0; rail1_setup = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1", "reset outputs", pwr_vec(), RUN_VEC);
        chk("R1", "reset cmd_valid", int'(cmd_valid), 0);
        rst = 1'b0;
        tick();
        chk("R1", "after reset outputs", pwr_vec(), RUN_VEC);
        chk("R1", "after reset handoff", int'(handoff), 0);

        for (int ow = 0; ow < 3; ow++)
            for (int lw = 0; lw < 3; lw++)
                for (int s2 = 0; s2 < 2; s2++)
                    for (int s1 = 0; s1 < 3; s1++)
                        for (int leg = 0; leg < 2; leg++)
                            run_case(ow, lw, s2, s1, leg, (ow + s1) % 3, (lw + s2) % 2);

        // Longer counts at the edge of the sweep
        run_case(7, 2, 5, 9, 0, 4, 1);
        run_case(1, 12, 0, 0, 1, 0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end
endmodule